// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block drives the command pins of a single-rank SDRAM from the controller side. After a synchronous reset it holds the device quiet for a programmable settling time, then brings it up. Bring-up closes every bank, runs a burst of auto-refresh cycles and loads the mode word. Each gap between these steps is counted in clock cycles.

Once bring-up is complete, the block keeps the array refreshed. It owes one refresh every `REF_INTERVAL_CYC` cycles, which is 1562 cycles at 100 MHz and gives 4096 refreshes in 64 ms. It grants the command bus to a single user port between refreshes. The user holds `user_req` while it owns the bus. When refreshes are owed the block raises `ref_due`, and the user gives the bus back by dropping its request. The block then closes every bank and pays off all owed refreshes back to back before it grants the bus again. Read and write data handling sits outside this block. While the grant is held, the sequencer drives NOP and an external multiplexer selects the user's commands.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and after reset, and until `init_done` rises, `sd_cke` is 1, every `sd_dqm` bit is 1 and the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111). No other command appears before cycle `T_INIT_CYC`, counted from the first clock edge after reset is released.
- R2: The first command is precharge-all (`{cs_n,ras_n,cas_n,we_n}` = 0010 with `sd_addr[10]` = 1), issued in cycle `T_INIT_CYC`.
- R3: `T_RP_CYC` cycles after that precharge, `INIT_REFRESHES` auto-refresh commands (0001) follow, spaced `T_RC_CYC` cycles apart.
- R4: `T_RC_CYC` cycles after the last start-up refresh, exactly one mode-register load (0000) is issued, and it is never issued again. Its address carries the mode word: burst length code in bits 2..0, burst type in bit 3 (1 = interleaved), CAS latency in bits 6..4 (010 = 2, 011 = 3), zeros in bits 8..7, write mode in bit 9 (1 = single-location writes) and zeros in bits 11..10.
- R5: `init_done` rises `T_RSC_CYC` cycles after the mode load and then stays high. In the same cycle `sd_dqm` goes to all zeros.
- R6: One refresh becomes owed every `REF_INTERVAL_CYC` cycles, counted from the cycle after `init_done` rises. An idle sequencer with a debt issues precharge-all in the next cycle, and an auto-refresh `T_RP_CYC` cycles after it.
- R7: With `user_req` high, no debt and the sequencer idle, `user_gnt` rises in the next cycle. It stays high until `user_req` drops and falls in the cycle after the drop. While `user_gnt` is high, the command is NOP.
- R8: A debt that arises while the bus is granted raises `ref_due`, and no command is issued until the user releases the bus. One cycle after `user_gnt` falls, precharge-all is issued. One auto-refresh per owed refresh follows, `T_RP_CYC` after the precharge and `T_RC_CYC` apart.
- R9: The debt saturates at `MAX_PENDING`, so a long hold-off produces at most that many refreshes in the catch-up burst.
- R10: When the sequencer is idle with a debt, the debt takes priority over a pending `user_req`. The grant is given only in the cycle after the sequencer returns to idle with no debt left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all behaviour on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| user_req | input | 1 | User asks for, and holds, ownership of the command bus |
| user_gnt | output | 1 | Bus granted to the user |
| ref_due | output | 1 | At least one refresh is owed |
| init_done | output | 1 | Bring-up finished; stays high |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address (driven zero by this block) |
| sd_addr | output | ADDR_W | Address lines: A10 precharge-all flag, mode word |
| sd_dqm | output | DQM_W | Data mask lines, all high during bring-up |

## Verification
The assertions rely on the user port keeping to the handshake: `user_req` must fall once `ref_due` is seen. They also assume every cycle-count parameter is at least 2 and that the refresh interval is longer than a full catch-up burst. The stimulus changes `user_req` only at falling clock edges and at cycles it picks in advance. It always releases the bus after a chosen hold. It raises the request once in the same cycle as a debt, to exercise priority. It holds the bus across six intervals to drive the debt into saturation.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command code as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOADMODE = 4'b0000,
    CMD_AUTOREF  = 4'b0001,
    CMD_PRECHG   = 4'b0010,
    CMD_NOP      = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PRECHG,
    ST_PRECHG_WAIT,
    ST_AUTOREF,
    ST_AUTOREF_WAIT,
    ST_LOADMODE,
    ST_LOADMODE_WAIT,
    ST_IDLE,
    ST_USER
  } seq_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Mode word laid out on address bits 11..0
  function automatic logic [11:0] build_mode(int cas_lat, logic [2:0] bl_code,
                                             logic interleaved, logic single_wr);
    logic [2:0] cl_code;
    cl_code = 3'(cas_lat);
    return {2'b00, single_wr, 2'b00, cl_code, interleaved, bl_code};
  endfunction

  function automatic sdram_cmd_e cmd_for(seq_state_e st);
    case (st)
      ST_PRECHG:   return CMD_PRECHG;
      ST_AUTOREF:  return CMD_AUTOREF;
      ST_LOADMODE: return CMD_LOADMODE;
      default:     return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int W     = 16,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(START);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int INTERVAL_CYC = 1562,
  parameter int MAX_OWED     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic take,
  output logic due
);

  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [TW-1:0] tick_cnt_q;
  logic [OW-1:0] owed_q;
  logic          tick;
  logic          add_one;
  logic          sub_one;

  assign tick    = run && (tick_cnt_q == TW'(INTERVAL_CYC - 1));
  assign add_one = tick && (owed_q != OW'(MAX_OWED));
  assign sub_one = take && (owed_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt_q <= '0;
    end else if (run) begin
      tick_cnt_q <= tick ? '0 : tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else begin
      case ({add_one, sub_one})
        2'b10:   owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign due = (owed_q != '0);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int         T_INIT_CYC        = 50000,
  parameter int         T_RP_CYC          = 2,
  parameter int         T_RC_CYC          = 7,
  parameter int         T_RSC_CYC         = 2,
  parameter int         INIT_REFRESHES    = 8,
  parameter int         REF_INTERVAL_CYC  = 1562,
  parameter int         MAX_PENDING       = 8,
  parameter int         CAS_LATENCY       = 3,
  parameter logic [2:0] BURST_LEN_CODE    = 3'b011,
  parameter logic       BURST_INTERLEAVED = 1'b0,
  parameter logic       WRITE_SINGLE      = 1'b0,
  parameter int         ADDR_W            = 12,
  parameter int         BANK_W            = 2,
  parameter int         DQM_W             = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_req,
  output logic              user_gnt,
  output logic              ref_due,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm
);

  localparam int TMR_W = $clog2(max_of4(T_INIT_CYC, T_RP_CYC, T_RC_CYC, T_RSC_CYC) + 1);
  localparam int IW    = $clog2(INIT_REFRESHES + 1);
  localparam logic [11:0] MODE_WORD =
    build_mode(CAS_LATENCY, BURST_LEN_CODE, BURST_INTERLEAVED, WRITE_SINGLE);
  localparam logic [ADDR_W-1:0] PRECHG_ALL_ADDR = ADDR_W'(1) << 10;

  seq_state_e       state_q, state_d;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             debt_take;
  logic             debt_due;
  logic [IW-1:0]    init_refs_q;
  logic             done_q, done_d;
  logic [3:0]       cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQM_W-1:0] dqm_q;
  logic             gnt_q;

  seq_wait_timer #(
    .W     (TMR_W),
    .START (T_INIT_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  refresh_debt #(
    .INTERVAL_CYC (REF_INTERVAL_CYC),
    .MAX_OWED     (MAX_PENDING)
  ) u_debt (
    .clk  (clk),
    .rst  (rst),
    .run  (done_q),
    .take (debt_take),
    .due  (debt_due)
  );

  // Next-state selection; each command state loads the timer with the
  // spacing to the following command minus the command cycle itself.
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    debt_take = 1'b0;
    case (state_q)
      ST_SETTLE: begin
        if (tmr_expired) state_d = ST_PRECHG;
      end
      ST_PRECHG: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RP_CYC - 2);
        state_d  = ST_PRECHG_WAIT;
      end
      ST_PRECHG_WAIT: begin
        if (tmr_expired) state_d = ST_AUTOREF;
      end
      ST_AUTOREF: begin
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(T_RC_CYC - 2);
        debt_take = done_q;
        state_d   = ST_AUTOREF_WAIT;
      end
      ST_AUTOREF_WAIT: begin
        if (tmr_expired) begin
          if (!done_q) begin
            state_d = (init_refs_q == IW'(INIT_REFRESHES)) ? ST_LOADMODE : ST_AUTOREF;
          end else begin
            state_d = debt_due ? ST_AUTOREF : ST_IDLE;
          end
        end
      end
      ST_LOADMODE: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RSC_CYC - 2);
        state_d  = ST_LOADMODE_WAIT;
      end
      ST_LOADMODE_WAIT: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (debt_due)      state_d = ST_PRECHG;
        else if (user_req) state_d = ST_USER;
      end
      ST_USER: begin
        if (!user_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign done_d = done_q || (state_d == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SETTLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_refs_q <= '0;
    end else if (state_q == ST_AUTOREF && !done_q) begin
      init_refs_q <= init_refs_q + 1'b1;
    end
  end

  // Registered pin drivers, computed from the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      dqm_q  <= '1;
      gnt_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      cmd_q  <= cmd_for(state_d);
      gnt_q  <= (state_d == ST_USER);
      dqm_q  <= done_d ? '0 : '1;
      case (state_d)
        ST_PRECHG:   addr_q <= PRECHG_ALL_ADDR;
        ST_LOADMODE: addr_q <= ADDR_W'(MODE_WORD);
        default:     addr_q <= '0;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = 1'b1;
  assign sd_ba     = '0;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign user_gnt  = gnt_q;
  assign init_done = done_q;
  assign ref_due   = debt_due;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DQM_W     = 8,
  parameter int T_RP_CYC  = 2,
  parameter int T_RC_CYC  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              user_req,
  input logic              user_gnt,
  input logic              ref_due,
  input logic              init_done,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm
);

  logic [3:0]  cmd;
  logic [3:0]  last_cmd_q;
  logic [15:0] gap_q;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // Cycles since the previous non-NOP command, and what it was
  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd_q <= CMD_NOP;
      gap_q      <= '0;
    end else if (cmd != CMD_NOP) begin
      last_cmd_q <= cmd;
      gap_q      <= 16'd1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (rst)
    sd_cke);  // R1
  AST_DQM_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (&sd_dqm));  // R1
  AST_PRECHG_ALL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRECHG) |-> sd_addr[10]);  // R2
  AST_REF_AFTER_PRECHG: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_AUTOREF && last_cmd_q == CMD_PRECHG) |-> (gap_q >= 16'(T_RP_CYC)));  // R3
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_AUTOREF && last_cmd_q == CMD_AUTOREF) |-> (gap_q >= 16'(T_RC_CYC)));  // R3
  AST_MODE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOADMODE) |-> (last_cmd_q == CMD_AUTOREF && gap_q >= 16'(T_RC_CYC)));  // R4
  AST_MODE_ONLY_AT_INIT: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOADMODE) |-> !init_done);  // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);  // R5
  AST_GNT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    user_gnt |-> init_done);  // R7
  AST_QUIET_WHILE_GNT: assert property (@(posedge clk) disable iff (rst)
    user_gnt |-> (cmd == CMD_NOP));  // R7
  AST_GNT_HOLDS_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    (user_gnt && user_req) |=> user_gnt);  // R8
  AST_GNT_NO_DEBT: assert property (@(posedge clk) disable iff (rst)
    $rose(user_gnt) |-> ($past(user_req) && !$past(ref_due)));  // R10

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DQM_W    (DQM_W),
  .T_RP_CYC (T_RP_CYC),
  .T_RC_CYC (T_RC_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .user_req  (user_req),
  .user_gnt  (user_gnt),
  .ref_due   (ref_due),
  .init_done (init_done),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_dqm    (sd_dqm)
);

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;
  import sdram_seq_pkg::*;

  localparam int TI = 20, TRP = 3, TRC = 5, TRSC = 2, NREF = 8, IVL = 60, MAXP = 4;
  localparam int AW = 12, BW = 2, DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, user_req, user_gnt, ref_due, init_done;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BW-1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic [DW-1:0] sd_dqm;

  sdram_cmd_seq #(
    .T_INIT_CYC (TI), .T_RP_CYC (TRP), .T_RC_CYC (TRC), .T_RSC_CYC (TRSC),
    .INIT_REFRESHES (NREF), .REF_INTERVAL_CYC (IVL), .MAX_PENDING (MAXP),
    .CAS_LATENCY (2), .BURST_LEN_CODE (3'b010), .BURST_INTERLEAVED (1'b1),
    .WRITE_SINGLE (1'b1), .ADDR_W (AW), .BANK_W (BW), .DQM_W (DW)
  ) uut (
    .clk (clk), .rst (rst), .user_req (user_req), .user_gnt (user_gnt),
    .ref_due (ref_due), .init_done (init_done), .sd_cke (sd_cke),
    .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
    .sd_we_n (sd_we_n), .sd_ba (sd_ba), .sd_addr (sd_addr), .sd_dqm (sd_dqm)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // Scoreboard of expected commands: cycle, code, address (-1 = any), tag
  int         q_at[$];
  logic [3:0] q_cmd[$];
  int         q_addr[$];
  string      q_tag[$];

  task automatic push(int at, logic [3:0] c, int a, string tag);
    q_at.push_back(at); q_cmd.push_back(c); q_addr.push_back(a); q_tag.push_back(tag);
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Monitor: pops one expected item per observed command
  logic [3:0] seen;
  always @(negedge clk) begin
    seen = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst && seen != CMD_NOP) begin
      vectors++;
      if (q_at.size() == 0) begin
        miscompares++;
        $display("FAIL R8 unexpected command %b at cycle %0d expected none", seen, cyc);
      end else begin
        automatic int         e_at   = q_at.pop_front();
        automatic logic [3:0] e_cmd  = q_cmd.pop_front();
        automatic int         e_addr = q_addr.pop_front();
        automatic string      e_tag  = q_tag.pop_front();
        if (seen != e_cmd || cyc != e_at ||
            (e_addr >= 0 && int'(sd_addr) != e_addr)) begin
          miscompares++;
          $display("FAIL %s command %b@%0d addr %h expected %b@%0d addr %h",
                   e_tag, seen, cyc, sd_addr, e_cmd, e_at, e_addr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d expected end of run", cyc);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    user_req = 1'b0;
    // R2 precharge-all, R3 start-up refreshes, R4 mode word 0x22A
    push(TI, CMD_PRECHG, 'h400, "R2");
    for (int i = 0; i < NREF; i++) push(TI + TRP + TRC * i, CMD_AUTOREF, -1, "R3");
    push(TI + TRP + TRC * (NREF - 1) + TRC, CMD_LOADMODE, 'h22A, "R4");
    // R6 periodic refresh while idle
    push(126, CMD_PRECHG, 'h400, "R6"); push(129, CMD_AUTOREF, -1, "R6");
    push(186, CMD_PRECHG, 'h400, "R6"); push(189, CMD_AUTOREF, -1, "R6");
    // R8 catch-up after a grant held across two debts
    push(332, CMD_PRECHG, 'h400, "R8"); push(335, CMD_AUTOREF, -1, "R8");
    push(340, CMD_AUTOREF, -1, "R8");
    // R10 debt beats a simultaneous request
    push(366, CMD_PRECHG, 'h400, "R10"); push(369, CMD_AUTOREF, -1, "R10");
    // R9 saturated debt: exactly MAXP refreshes
    push(732, CMD_PRECHG, 'h400, "R9");
    for (int i = 0; i < MAXP; i++) push(735 + TRC * i, CMD_AUTOREF, -1, "R9");
    push(786, CMD_PRECHG, 'h400, "R6"); push(789, CMD_AUTOREF, -1, "R6");

    repeat (3) @(negedge clk);
    check("R1 reset cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
    check("R1 reset cke", sd_cke, 1);
    check("R1 reset dqm", sd_dqm, 'hFF);
    check("R1 reset done", init_done, 0);
    check("R7 reset gnt", user_gnt, 0);
    rst = 1'b0;
    user_req = 1'b1;              // ignored during bring-up (R7 needs init_done)
    wait_cyc(10);
    check("R1 settle dqm", sd_dqm, 'hFF);
    check("R7 no grant before done", user_gnt, 0);
    user_req = 1'b0;
    wait_cyc(64);
    check("R5 done before rsc", init_done, 0);
    wait_cyc(65);
    check("R5 done rises", init_done, 1);
    check("R5 dqm released", sd_dqm, 0);
    wait_cyc(125);
    check("R6 debt raised", ref_due, 1);
    wait_cyc(200);
    user_req = 1'b1;
    check("R7 gnt before edge", user_gnt, 0);
    wait_cyc(201);
    check("R7 gnt rises", user_gnt, 1);
    wait_cyc(250);
    check("R8 ref_due while granted", ref_due, 1);
    check("R8 gnt kept", user_gnt, 1);
    wait_cyc(330);
    user_req = 1'b0;
    wait_cyc(331);
    check("R7 gnt falls", user_gnt, 0);
    wait_cyc(345);
    check("R8 debt cleared", ref_due, 0);
    wait_cyc(365);
    user_req = 1'b1;
    wait_cyc(367);
    check("R10 no grant with debt", user_gnt, 0);
    wait_cyc(374);
    check("R10 grant waits for idle", user_gnt, 0);
    wait_cyc(375);
    check("R10 grant after service", user_gnt, 1);
    wait_cyc(380);
    user_req = 1'b0;
    wait_cyc(381);
    check("R7 release", user_gnt, 0);
    wait_cyc(385);
    user_req = 1'b1;
    wait_cyc(700);
    check("R9 gnt across debts", user_gnt, 1);
    check("R9 ref_due", ref_due, 1);
    wait_cyc(730);
    user_req = 1'b0;
    wait_cyc(800);
    check("R8 all expected commands seen", q_at.size(), 0);
    check("R5 done sticky", init_done, 1);
    finish_run();
  end

endmodule